// File: doc/BRIEF.md
# Trace Start/Stop Trigger Emitter

This block watches the trace-start and trace-stop event pulses that a group of processors raise. It turns them into a one-cycle trigger marker on the trace port's control and data lines. Software sets it up with one write-only configuration word. Four enable bits in that word pick which kinds of marker are sent: an immediate or a delayed marker on a start event, and an immediate or a delayed marker on a stop event. An 8-bit field in the same word gives the delay in units of 256 trace clock cycles.

Events from all processors are merged, so a start or stop in any of them arms the matching trigger. Each delayed trigger has its own down-counter. A new event while a delay is pending reloads that counter. Clearing the delayed enable drops whatever is pending. Markers that fall in the same cycle merge into a single marker.

Top module: `trace_trig_emitter`

## Requirements
- R1: While no marker is sent, the control line is 0 and the data lines read 2'b00. A marker is the control line at 1 together with data 2'b10. Both lines are idle after reset.
- R2: A cycle with the write strobe high loads the configuration word, and the new value applies to events from the next cycle on. After reset every field is zero, so no event produces a marker. Bits 31:14, 9 and 8 have no effect.
- R3: With bit 13 set, a stop event sampled at a clock edge produces a marker in the cycle that follows that edge.
- R4: With bit 12 set and delay field D (bits 7:0) nonzero, a stop event produces a marker exactly 256*D cycles later than an immediate marker for the same event would appear.
- R5: With bit 11 set, a start event produces a marker in the cycle that follows the sampling edge.
- R6: With bit 10 set and D nonzero, a start event produces a marker 256*D cycles after the immediate position.
- R7: A pulse on any one processor's start or stop line arms the trigger for that event kind. Pulses from several processors in the same cycle count as one event.
- R8: With D equal to 0, a delayed trigger fires in the immediate position. Markers that fall in the same cycle, from any mix of sources, merge into one marker.
- R9: An event that arrives while a delayed trigger of its kind is pending restarts the full delay. Only the restarted delay produces a marker.
- R10: The largest delay, D=255, places the marker 65280 cycles after the immediate position.
- R11: Writing the configuration with a delayed enable cleared cancels any pending delayed trigger of that kind, and no marker follows.
- R12: Each firing drives the marker for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Trace clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word |
| start_evt | input | NUM_CPU | Per-processor trace-start pulses |
| stop_evt | input | NUM_CPU | Per-processor trace-stop pulses |
| trc_ctl | output | 1 | Trace control line, high during a marker |
| trc_data | output | 2 | Trace data lines, 2'b10 during a marker |

## Verification
The bench sweeps all sixteen combinations of the four enable bits, first against a lone start event and then against a lone stop event, each from a different processor. It compares the cycle of the first marker and the number of marker cycles with values worked out from the enable bits and the delay. This separates the start path from the stop path and the immediate trigger from the delayed one. Further patterns cover the rest: a pulse on each processor line on its own and several at once, which shows the events are merged; a zero delay and simultaneous start and stop events, which show markers merging; a second event in the middle of a delay, which shows the restart; the largest delay; and an enable cleared while a delay is pending, which shows the cancel.

// File: rtl/trig_pkg.sv
package trig_pkg;
    // Enable bit positions in the configuration word
    localparam int BIT_IMM_STOP  = 13;
    localparam int BIT_DLY_STOP  = 12;
    localparam int BIT_IMM_START = 11;
    localparam int BIT_DLY_START = 10;
    // Delay field and its unit
    localparam int DLY_LSB    = 0;
    localparam int DLY_W      = 8;
    localparam int UNIT_SHIFT = 8;
    localparam int CNT_W      = DLY_W + UNIT_SHIFT;
    // Timer slots
    localparam int SLOT_STOP  = 0;
    localparam int SLOT_START = 1;
    localparam int NUM_SLOT   = 2;
    // Line codes
    localparam logic [1:0] MARK_CODE = 2'b10;
    localparam logic [1:0] IDLE_CODE = 2'b00;

    typedef struct packed {
        logic             imm_stop;
        logic             dly_stop;
        logic             imm_start;
        logic             dly_start;
        logic [DLY_W-1:0] delay;
    } cfg_t;
endpackage

// File: rtl/trig_cfg_reg.sv
module trig_cfg_reg
    import trig_pkg::*;
#(
    parameter int CFG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output cfg_t             cfg
);
    typedef struct packed {
        cfg_t cfg;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (we) begin
            s_d.cfg.imm_stop  = wdata[BIT_IMM_STOP];
            s_d.cfg.dly_stop  = wdata[BIT_DLY_STOP];
            s_d.cfg.imm_start = wdata[BIT_IMM_START];
            s_d.cfg.dly_start = wdata[BIT_DLY_START];
            s_d.cfg.delay     = wdata[DLY_LSB +: DLY_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cfg = s_q.cfg;
endmodule

// File: rtl/trig_evt_merge.sv
module trig_evt_merge #(
    parameter int NUM_CPU = 4
) (
    input  logic [NUM_CPU-1:0] start_vec,
    input  logic [NUM_CPU-1:0] stop_vec,
    output logic               any_start,
    output logic               any_stop
);
    always_comb begin
        any_start = 1'b0;
        any_stop  = 1'b0;
        for (int i = 0; i < NUM_CPU; i++) begin
            any_start = any_start | start_vec[i];
            any_stop  = any_stop  | stop_vec[i];
        end
    end
endmodule

// File: rtl/trig_delay_timer.sv
module trig_delay_timer
    import trig_pkg::*;
#(
    parameter int DW    = DLY_W,
    parameter int SHIFT = UNIT_SHIFT,
    localparam int CW   = DW + SHIFT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          evt,
    input  logic [DW-1:0] delay,
    output logic          fire,
    output logic          pending,
    output logic [CW-1:0] count
);
    typedef struct packed {
        logic          pend;
        logic [CW-1:0] cnt;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        fire = 1'b0;
        if (!en) begin
            s_d.pend = 1'b0;
            s_d.cnt  = '0;
        end else if (evt) begin
            if (delay == '0) begin
                fire     = 1'b1;
                s_d.pend = 1'b0;
                s_d.cnt  = '0;
            end else begin
                s_d.pend = 1'b1;
                s_d.cnt  = {delay, {SHIFT{1'b0}}};
            end
        end else if (s_q.pend) begin
            if (s_q.cnt == CW'(1)) begin
                fire     = 1'b1;
                s_d.pend = 1'b0;
                s_d.cnt  = '0;
            end else begin
                s_d.cnt = s_q.cnt - CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pending = s_q.pend;
    assign count   = s_q.cnt;
endmodule

// File: rtl/trace_trig_emitter.sv
module trace_trig_emitter
    import trig_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int CFG_W   = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [CFG_W-1:0]   cfg_wdata,
    input  logic [NUM_CPU-1:0] start_evt,
    input  logic [NUM_CPU-1:0] stop_evt,
    output logic               trc_ctl,
    output logic [1:0]         trc_data
);
    cfg_t cfg_q;
    logic any_start, any_stop;
    logic [NUM_SLOT-1:0]            en_v, evt_v, fire_v, pend_v;
    logic [NUM_SLOT-1:0][CNT_W-1:0] cnt_v;

    typedef struct packed {
        logic mark;
    } state_t;

    state_t s_d, s_q;

    trig_cfg_reg #(.CFG_W(CFG_W)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg_q)
    );

    trig_evt_merge #(.NUM_CPU(NUM_CPU)) u_merge (
        .start_vec (start_evt),
        .stop_vec  (stop_evt),
        .any_start (any_start),
        .any_stop  (any_stop)
    );

    assign en_v[SLOT_STOP]   = cfg_q.dly_stop;
    assign en_v[SLOT_START]  = cfg_q.dly_start;
    assign evt_v[SLOT_STOP]  = any_stop;
    assign evt_v[SLOT_START] = any_start;

    for (genvar g = 0; g < NUM_SLOT; g++) begin : g_timer
        trig_delay_timer #(.DW(DLY_W), .SHIFT(UNIT_SHIFT)) u_tmr (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (en_v[g]),
            .evt     (evt_v[g]),
            .delay   (cfg_q.delay),
            .fire    (fire_v[g]),
            .pending (pend_v[g]),
            .count   (cnt_v[g])
        );
    end

    always_comb begin
        s_d      = s_q;
        s_d.mark = (cfg_q.imm_stop & any_stop) | (cfg_q.imm_start & any_start) | (|fire_v);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign trc_ctl  = s_q.mark;
    assign trc_data = s_q.mark ? MARK_CODE : IDLE_CODE;
endmodule

// File: rtl/trig_chk.sv
module trig_chk
    import trig_pkg::*;
#(
    parameter int NUM_CPU = 4
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [NUM_CPU-1:0]             start_vec,
    input logic [NUM_CPU-1:0]             stop_vec,
    input cfg_t                           cfg,
    input logic [NUM_SLOT-1:0]            fire_v,
    input logic [NUM_SLOT-1:0]            pend_v,
    input logic [NUM_SLOT-1:0][CNT_W-1:0] cnt_v,
    input logic                           trc_ctl,
    input logic [1:0]                     trc_data
);
    localparam logic [CNT_W-1:0] MAX_CNT = {{DLY_W{1'b1}}, {UNIT_SHIFT{1'b0}}};

    AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        !trc_ctl |-> trc_data == IDLE_CODE); // R1
    AST_MARK_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        trc_ctl |-> trc_data == MARK_CODE); // R1
    AST_IMM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.imm_stop && |stop_vec) |=> trc_ctl); // R3
    AST_IMM_START: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.imm_start && |start_vec) |=> trc_ctl); // R5
    AST_DLY_STOP_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        fire_v[SLOT_STOP] |=> trc_ctl); // R4
    AST_DLY_START_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        fire_v[SLOT_START] |=> trc_ctl); // R6
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        trc_ctl |-> $past((cfg.imm_stop && |stop_vec) || (cfg.imm_start && |start_vec) || (|fire_v))); // R12
    AST_STOP_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        pend_v[SLOT_STOP] |-> (cnt_v[SLOT_STOP] != '0 && cnt_v[SLOT_STOP] <= MAX_CNT)); // R10
    AST_START_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        pend_v[SLOT_START] |-> (cnt_v[SLOT_START] != '0 && cnt_v[SLOT_START] <= MAX_CNT)); // R10
    AST_STOP_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.dly_stop |=> !pend_v[SLOT_STOP]); // R11
    AST_START_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.dly_start |=> !pend_v[SLOT_START]); // R11
    AST_START_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.dly_start && |start_vec && cfg.delay != '0) |=>
        (pend_v[SLOT_START] && cnt_v[SLOT_START] == {$past(cfg.delay), {UNIT_SHIFT{1'b0}}})); // R9
endmodule

bind trace_trig_emitter trig_chk #(.NUM_CPU(NUM_CPU)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_vec (start_evt),
    .stop_vec  (stop_evt),
    .cfg       (cfg_q),
    .fire_v    (fire_v),
    .pend_v    (pend_v),
    .cnt_v     (cnt_v),
    .trc_ctl   (trc_ctl),
    .trc_data  (trc_data)
);

// File: tb/tb_trace_trig_emitter.sv
module tb_trace_trig_emitter;
    localparam int NCPU = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_we = 1'b0;
    logic [31:0]     cfg_wdata = '0;
    logic [NCPU-1:0] start_evt = '0;
    logic [NCPU-1:0] stop_evt = '0;
    logic            trc_ctl;
    logic [1:0]      trc_data;

    int n_chk = 0;
    int n_fail = 0;
    int bad_code = 0;

    trace_trig_emitter #(.NUM_CPU(NCPU), .CFG_W(32)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .trc_ctl   (trc_ctl),
        .trc_data  (trc_data)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] w);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
        cfg_wdata = '0;
    endtask

    // Index 0 is the cycle right after the edge that samples the pulses.
    task automatic watch(input logic [NCPU-1:0] st, input logic [NCPU-1:0] sp, input int win,
                         output int first, output int cnt);
        first = -1;
        cnt = 0;
        @(negedge clk);
        start_evt = st;
        stop_evt = sp;
        @(negedge clk);
        start_evt = '0;
        stop_evt = '0;
        for (int i = 0; i < win; i++) begin
            if (i > 0) @(negedge clk);
            if (trc_ctl) begin
                cnt++;
                if (first < 0) first = i;
                if (trc_data != 2'b10) bad_code++;
            end else if (trc_data != 2'b00) begin
                bad_code++;
            end
        end
    endtask

    function automatic logic [31:0] cfg_word(input int en4, input int d);
        return (32'(en4) << 10) | 32'(d & 255);
    endfunction

    // Expected first index and marker count for one event kind.
    task automatic expect_of(input bit imm, input bit dly, input int d, output int ef, output int ec);
        int tdly;
        tdly = 256 * d;
        ef = -1;
        ec = 0;
        if (imm) begin ef = 0; ec = 1; end
        if (dly) begin
            if (ef < 0 || tdly < ef) ef = tdly;
            if (!(imm && tdly == 0)) ec++;
        end
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        int f, c, ef, ec;
        repeat (3) @(negedge clk);
        // R1: idle lines after reset
        check(trc_ctl == 1'b0, "R1", "ctl in reset", int'(trc_ctl), 0);
        check(trc_data == 2'b00, "R1", "data in reset", int'(trc_data), 0);
        rst_n = 1'b1;

        // R2: reset configuration is all zero, so events give no marker
        watch(4'hF, 4'hF, 300, f, c);
        check(c == 0, "R2", "markers with reset config", c, 0);

        // R2: ignored bits 31:14, 9, 8 with enables clear
        wr(32'hFFFF_C300 | 32'd1);
        watch(4'hF, 4'hF, 300, f, c);
        check(c == 0, "R2", "markers with only ignored bits", c, 0);

        // R3/R4/R5/R6: sweep over all enable combinations, D=1
        for (int m = 0; m < 16; m++) begin
            for (int ev = 0; ev < 2; ev++) begin
                logic [NCPU-1:0] one;
                one = NCPU'(1) << (m % NCPU);
                wr(cfg_word(m, 1));
                if (ev == 0) begin
                    watch('0, one, 300, f, c);
                    expect_of(m[3], m[2], 1, ef, ec);
                    check(f == ef, "R3/R4", $sformatf("stop first, en=%0h", m), f, ef);
                    check(c == ec, "R3/R4/R12", $sformatf("stop count, en=%0h", m), c, ec);
                end else begin
                    watch(one, '0, 300, f, c);
                    expect_of(m[1], m[0], 1, ef, ec);
                    check(f == ef, "R5/R6", $sformatf("start first, en=%0h", m), f, ef);
                    check(c == ec, "R5/R6/R12", $sformatf("start count, en=%0h", m), c, ec);
                end
            end
        end

        // R7: every processor line, then all at once
        wr(cfg_word(4'b1010, 0));
        for (int i = 0; i < NCPU; i++) begin
            watch(NCPU'(1) << i, '0, 4, f, c);
            check(f == 0 && c == 1, "R7", $sformatf("start cpu %0d first", i), f, 0);
            watch('0, NCPU'(1) << i, 4, f, c);
            check(f == 0 && c == 1, "R7", $sformatf("stop cpu %0d first", i), f, 0);
        end
        watch(4'hF, '0, 4, f, c);
        check(c == 1, "R7", "all cpus start count", c, 1);

        // R8: zero delay with both start triggers merges into one marker
        wr(cfg_word(4'b0011, 0));
        watch(4'h2, '0, 4, f, c);
        check(f == 0, "R8", "zero delay first", f, 0);
        check(c == 1, "R8", "zero delay merged count", c, 1);
        // R8: start and stop together, all immediate and zero delay
        wr(cfg_word(4'b1111, 0));
        watch(4'h1, 4'h8, 4, f, c);
        check(c == 1, "R8", "start+stop merged count", c, 1);

        // R9: retrigger restarts delay
        wr(cfg_word(4'b0001, 1));
        watch(4'h4, '0, 100, f, c);
        check(c == 0, "R9", "no marker before retrigger", c, 0);
        watch(4'h8, '0, 300, f, c);
        check(f == 256, "R9", "restarted delay first", f, 256);
        check(c == 1, "R9", "restarted delay count", c, 1);

        // R10: largest delay on stop
        wr(cfg_word(4'b0100, 255));
        watch('0, 4'h1, 65290, f, c);
        check(f == 65280, "R10", "max delay first", f, 65280);
        check(c == 1, "R10", "max delay count", c, 1);

        // R11: clearing the enable cancels a pending delay
        wr(cfg_word(4'b0001, 2));
        watch(4'h1, '0, 50, f, c);
        check(c == 0, "R11", "none before cancel", c, 0);
        wr(cfg_word(4'b0000, 2));
        watch('0, '0, 600, f, c);
        check(c == 0, "R11", "none after cancel", c, 0);

        // R1: code on the lines during every observed cycle
        check(bad_code == 0, "R1", "line code mismatches", bad_code, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule